// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external side of a processor's memory and I/O traffic on a 16-bit bus that carries both the address and the data. A free-running four-phase clock is generated inside the block, with one system clock per phase. The core presents a request: read, write, or either of these flagged as an interrupt acknowledge. The sequencer then plays out a fixed pattern of strobes aligned to individual phases. The address goes out first under SYNC. The bus then either turns around for DIN, or carries write data under DOUT. The cycle closes with a one-clock done pulse and, for reads, the captured word.

The tri-state pads are modelled as an output value plus an output enable. An external BUSY line lets another master, such as a DMA engine, stall a transfer. BUSY is looked at only in phase 3 of each data cycle. While it is seen high, the data cycle repeats in whole four-phase steps with every strobe and the bus held steady.

Top module: `mbus_sequencer`

## Requirements
- R1: A synchronous reset drives SYNC, DIN, DOUT, IACK, the bus enable and done low in the cycle after reset is sampled, and the phase output shows phase 1 in that cycle.
- R2: `phase_o` is one-hot (bit 0 = phase 1 … bit 3 = phase 4) and advances one phase per clock, wrapping from phase 4 to phase 1.
- R3: When idle, a request is sampled only at the end of phase 4. SYNC and the bus enable rise at the following phase 1 with the address on `bus_out`. No strobe or bus enable is raised in idle phases.
- R4: On a read (`req_op` bit 0 = 0) the address stays on the bus through phase 1 of the second clock cycle. DIN rises at phase 2 of that cycle while the bus enable drops in the same phase, and the enable stays low while DIN is high.
- R5: A read captures `bus_in` as it stands in the last phase 4 of the transfer. `rd_data` shows that value from the next phase 1 and keeps it through later writes.
- R6: On a write (`req_op` bit 0 = 1) the write data and DOUT appear together at phase 1 of the second cycle. DOUT falls in the final phase 4 while the data is still driven, and the bus is released one phase later.
- R7: With `req_op` bit 1 = 1 (interrupt acknowledge), IACK rises with SYNC and stays high exactly as long as SYNC. IACK stays low otherwise.
- R8: BUSY is sampled only in phase 3 of a data cycle. Each sample seen high adds four phases with all strobes and the bus unchanged. BUSY at any other time has no effect on the timing.
- R9: SYNC, DIN, DOUT, IACK and the bus enable all fall at the phase 1 that ends the transfer, and done is high in exactly that one clock.
- R10: A request held while done pulses is accepted at the end of phase 4 of that same clock cycle, so SYNC rises again four clocks after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick per phase |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request pending |
| req_op | input | 2 | Bit 0 write, bit 1 interrupt acknowledge |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| busy_i | input | 1 | External master stall request |
| bus_in | input | 16 | Value seen on the shared bus pins |
| bus_out | output | 16 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus pad drive enable |
| sync_o | output | 1 | Address strobe, high for the whole transfer |
| din_o | output | 1 | Read data strobe |
| dout_o | output | 1 | Write data strobe |
| iack_o | output | 1 | Interrupt acknowledge marker |
| phase_o | output | 4 | One-hot four-phase clock |
| rd_data | output | 16 | Captured read word |
| done_o | output | 1 | One-clock transfer end pulse |

## Verification
The bench sweeps every operation code against zero to three stall samples, with and without BUSY held high in every phase where it must be ignored. It compares each strobe, the enable and the bus value phase by phase against a timeline worked out from the phase index. A design that sampled BUSY in the wrong phase, or at the wrong edge, would stretch or shorten the transfer by four phases and misalign every later check. A design that captured the read word one phase early or late would return the complemented value the bench drives in all other phases. Back-to-back requests probe whether the idle gap after done is exactly three phases, and a reset in mid-transfer checks that the bus is released at once.

// File: rtl/mbus_seq_pkg.sv
package mbus_seq_pkg;

    localparam int unsigned NUM_PHASES = 4;
    localparam int unsigned PH_W       = $clog2(NUM_PHASES);

    // phase index values the sequencer reacts to
    localparam logic [PH_W-1:0] PH_FIRST = PH_W'(0);
    localparam logic [PH_W-1:0] PH_TURN  = PH_W'(0);
    localparam logic [PH_W-1:0] PH_STALL = PH_W'(2);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(NUM_PHASES - 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       wr;
        logic       stall;
        logic       sync;
        logic       din;
        logic       dout;
        logic       iack;
        logic       oe;
        logic       sel_data;
        logic       done;
    } seq_regs_t;

endpackage

// File: rtl/mbus_phase_gen.sv
module mbus_phase_gen
    import mbus_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    output logic [PH_W-1:0]       ph_idx,
    output logic [NUM_PHASES-1:0] ph_onehot
);

    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = (ph_q == PH_LAST) ? PH_FIRST : ph_q + PH_W'(1);
        if (rst) begin
            ph_d = PH_FIRST;
        end
    end

    always_ff @(posedge clk) begin
        ph_q <= ph_d;
    end

    assign ph_idx = ph_q;

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_onehot
        assign ph_onehot[g] = (ph_q == PH_W'(g));
    end

endmodule

// File: rtl/mbus_seq_fsm.sv
module mbus_seq_fsm
    import mbus_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] ph_idx,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic            busy_i,
    output logic            accept,
    output logic            capture,
    output logic            sync_o,
    output logic            din_o,
    output logic            dout_o,
    output logic            iack_o,
    output logic            oe_o,
    output logic            sel_data,
    output logic            done_o
);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        accept   = 1'b0;
        capture  = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (ph_idx == PH_LAST && req_valid) begin
                    accept     = 1'b1;
                    r_d.st     = ST_ADDR;
                    r_d.wr     = req_op[0];
                    r_d.sync   = 1'b1;
                    r_d.iack   = req_op[1];
                    r_d.oe     = 1'b1;
                    r_d.sel_data = 1'b0;
                end
            end
            ST_ADDR: begin
                if (ph_idx == PH_LAST) begin
                    r_d.st    = ST_DATA;
                    r_d.stall = 1'b0;
                    if (r_q.wr) begin
                        r_d.sel_data = 1'b1;
                        r_d.dout     = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (ph_idx == PH_TURN && !r_q.wr) begin
                    r_d.oe  = 1'b0;
                    r_d.din = 1'b1;
                end
                if (ph_idx == PH_STALL) begin
                    r_d.stall = busy_i;
                    if (r_q.wr && !busy_i) begin
                        r_d.dout = 1'b0;
                    end
                end
                if (ph_idx == PH_LAST && !r_q.stall) begin
                    capture      = !r_q.wr;
                    r_d.st       = ST_IDLE;
                    r_d.sync     = 1'b0;
                    r_d.din      = 1'b0;
                    r_d.dout     = 1'b0;
                    r_d.iack     = 1'b0;
                    r_d.oe       = 1'b0;
                    r_d.sel_data = 1'b0;
                    r_d.done     = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (rst) begin
            r_d     = '0;
            r_d.st  = ST_IDLE;
            accept  = 1'b0;
            capture = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign sync_o   = r_q.sync;
    assign din_o    = r_q.din;
    assign dout_o   = r_q.dout;
    assign iack_o   = r_q.iack;
    assign oe_o     = r_q.oe;
    assign sel_data = r_q.sel_data;
    assign done_o   = r_q.done;

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic          sel_data,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic [DW-1:0] rd_data
);

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] wdat;
        logic [DW-1:0] rdat;
    } dp_regs_t;

    dp_regs_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (accept) begin
            p_d.addr = req_addr;
            p_d.wdat = req_wdata;
        end
        if (capture) begin
            p_d.rdat = bus_in;
        end
        if (rst) begin
            p_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    assign bus_out = sel_data ? p_q.wdat : p_q.addr;
    assign rd_data = p_q.rdat;

endmodule

// File: rtl/mbus_sequencer.sv
module mbus_sequencer
    import mbus_seq_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [DW-1:0]         req_addr,
    input  logic [DW-1:0]         req_wdata,
    input  logic                  busy_i,
    input  logic [DW-1:0]         bus_in,
    output logic [DW-1:0]         bus_out,
    output logic                  bus_oe,
    output logic                  sync_o,
    output logic                  din_o,
    output logic                  dout_o,
    output logic                  iack_o,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic [DW-1:0]         rd_data,
    output logic                  done_o
);

    logic [PH_W-1:0] ph_idx;
    logic            accept;
    logic            capture;
    logic            sel_data;

    mbus_phase_gen u_phase (
        .clk       (clk),
        .rst       (rst),
        .ph_idx    (ph_idx),
        .ph_onehot (phase_o)
    );

    mbus_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ph_idx    (ph_idx),
        .req_valid (req_valid),
        .req_op    (req_op),
        .busy_i    (busy_i),
        .accept    (accept),
        .capture   (capture),
        .sync_o    (sync_o),
        .din_o     (din_o),
        .dout_o    (dout_o),
        .iack_o    (iack_o),
        .oe_o      (bus_oe),
        .sel_data  (sel_data),
        .done_o    (done_o)
    );

    mbus_datapath #(.DW(DW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .sel_data  (sel_data),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/mbus_seq_checker.sv
module mbus_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] phase_o,
    input logic       busy_i,
    input logic       bus_oe,
    input logic       sync_o,
    input logic       din_o,
    input logic       dout_o,
    input logic       iack_o,
    input logic       done_o
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!sync_o && !din_o && !dout_o && !iack_o && !bus_oe && !done_o && phase_o[0])); // R1

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_o) == 1); // R2

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        phase_o[3] |=> phase_o[0]); // R2

    AST_SYNC_START: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> (phase_o[0] && bus_oe)); // R3

    AST_DIN_START: assert property (@(posedge clk) disable iff (rst)
        $rose(din_o) |-> (phase_o[1] && !bus_oe)); // R4

    AST_DIN_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        din_o |-> (!bus_oe && sync_o)); // R4

    AST_DOUT_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(dout_o) && !$past(rst)) |-> (bus_oe && phase_o[3])); // R6

    AST_IACK_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        iack_o |-> sync_o); // R7

    AST_IACK_STEADY: assert property (@(posedge clk) disable iff (rst)
        (sync_o && $past(sync_o)) |-> $stable(iack_o)); // R7

    AST_BUSY_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (phase_o[2] && busy_i && (din_o || dout_o)) |=> ##1 (sync_o && !done_o)); // R8

    AST_END_DONE: assert property (@(posedge clk) disable iff (rst)
        ($fell(sync_o) && !$past(rst)) |-> done_o); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

endmodule

bind mbus_sequencer mbus_seq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase_o),
    .busy_i  (busy_i),
    .bus_oe  (bus_oe),
    .sync_o  (sync_o),
    .din_o   (din_o),
    .dout_o  (dout_o),
    .iack_o  (iack_o),
    .done_o  (done_o)
);

// File: tb/mbus_sequencer_bench.sv
module mbus_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy_i = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe, sync_o, din_o, dout_o, iack_o, done_o;
    logic [3:0]  phase_o;
    logic [15:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit chained  = 1'b0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    mbus_sequencer u_mbus_sequencer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy_i(busy_i),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .sync_o(sync_o), .din_o(din_o), .dout_o(dout_o), .iack_o(iack_o),
        .phase_o(phase_o), .rd_data(rd_data), .done_o(done_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic quiet_chk(input string tag);
        chk({tag, " sync"}, int'(sync_o), 0);
        chk({tag, " din"},  int'(din_o),  0);
        chk({tag, " dout"}, int'(dout_o), 0);
        chk({tag, " iack"}, int'(iack_o), 0);
        chk({tag, " oe"},   int'(bus_oe), 0);
    endtask

    // called at a negedge; runs one whole transfer and returns in its done slot
    task automatic run_xfer(input logic [1:0] op, input logic [15:0] addr,
                            input logic [15:0] wdata, input logic [15:0] rdval,
                            input int nw, input bit glitch);
        int gap = 0;
        int last = 8 + 4 * nw;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_wdata = wdata;
        busy_i    = glitch;  // R8: ignored while idle
        bus_in    = ~rdval;
        while (phase_o != 4'b1000) begin
            quiet_chk("R3 idle");
            gap++;
            @(negedge clk);
        end
        quiet_chk("R3 idle");
        if (chained) chk("R10 gap after done", gap, 3);
        for (int k = 0; k <= last; k++) begin
            int ph;
            bit exp_oe, exp_din, exp_dout;
            @(negedge clk);
            ph = k % 4;
            chk("R2 phase", int'(phase_o), 1 << ph);
            chk("R9 sync", int'(sync_o), int'(k < last));
            chk("R9 done", int'(done_o), int'(k == last));
            chk("R7 iack", int'(iack_o), int'(k < last && op[1]));
            if (op[0]) begin
                exp_oe   = (k < last);
                exp_din  = 1'b0;
                exp_dout = (k >= 4 && k < last - 1);
            end else begin
                exp_oe   = (k <= 4);
                exp_din  = (k >= 5 && k < last);
                exp_dout = 1'b0;
            end
            chk("R4 din", int'(din_o), int'(exp_din));
            chk("R6 dout", int'(dout_o), int'(exp_dout));
            chk("R4 R6 oe", int'(bus_oe), int'(exp_oe));
            if (exp_oe) begin
                chk("R3 R6 bus value", int'(bus_out),
                    int'((op[0] && k >= 4) ? wdata : addr));
            end
            if (k == last) begin
                if (!op[0]) last_rd = rdval;
                chk("R5 read data", int'(rd_data), int'(last_rd));
                req_valid = 1'b0;
            end
            // inputs for the edge that closes slot k
            if (k >= 6 && ph == 2) busy_i = ((k - 6) / 4 < nw);
            else busy_i = glitch;
            bus_in = (k == last - 1) ? rdval : ~rdval;
        end
        chained = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state right after reset
        quiet_chk("R1 reset");
        chk("R1 done", int'(done_o), 0);
        chk("R1 phase", int'(phase_o), 1);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset in the middle of a write transfer
        req_valid = 1'b1; req_op = 2'b01; req_addr = 16'h0F0F; req_wdata = 16'h1234;
        while (!sync_o) @(negedge clk);
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        quiet_chk("R1 mid reset");
        chk("R1 mid phase", int'(phase_o), 1);
        rst = 1'b0;
        @(negedge clk);

        for (int op = 0; op < 4; op++) begin
            for (int nw = 0; nw < 4; nw++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [15:0] a = 16'h8000 + 16'(op * 16'h0123 + nw * 16'h0041 + g);
                    logic [15:0] w = 16'h5A00 ^ 16'(op * 16'h0311 + nw * 16'h1005);
                    logic [15:0] d = 16'hC300 + 16'(op * 16'h0107 + nw * 16'h0020 + g * 3);
                    run_xfer(2'(op), a, w, d, nw, g[0]);
                end
            end
        end
        // R10: gap restarts after a pause, then one last chained pair
        chained = 1'b0;
        repeat (6) begin
            @(negedge clk);
            quiet_chk("R3 pause");
        end
        run_xfer(2'b00, 16'h0001, 16'h0000, 16'hFFFF, 0, 1'b1);
        run_xfer(2'b11, 16'hFFFE, 16'h8001, 16'h0000, 1, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule